// File: doc/BRIEF.md
# AES-128 Round Key Sequencer

This block expands a 128-bit cipher key into the eleven round keys that an AES-128 datapath consumes, producing one round key per clock. A single-cycle load strobe captures the cipher key; from the next cycle the block presents round key 0, which is the cipher key itself, and then round keys 1 to 10 on consecutive cycles. Each output cycle carries the round index and a valid flag.

Each new four-word key comes from the previous one. The last word of the previous key is rotated by one byte and passed through the S-box byte by byte. It is then combined with a round constant that is picked by the round number. That result is chained through the four words by XOR. The round-10 key is also kept in a separate register. It stays there after the sequence ends, so a decryption datapath can start from it.

Word 0 of a key occupies bits 127:96 and byte a0 of a word is its most significant byte. This matches the usual hexadecimal writing of keys.

Top module: `aes128_rkey_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, rkey_vld_o and final_vld_o are 0, round_o is 0 and rkey_o and final_key_o are all zeros.
- R2: When load_i is 1 at a clock edge, after that edge rkey_o equals the cipher_key_i value sampled at that edge, round_o is 0 and rkey_vld_o is 1.
- R3: After a load, round_o steps up by exactly one on each clock edge, from 0 to 10, with rkey_vld_o held at 1. On the edge after round 10 is shown, rkey_vld_o falls to 0.
- R4: Round key r (r from 1 to 10) satisfies the following, with words w0 to w3 taken from bits 127:96 down to 31:0. Let t be the previous w3 rotated left by one byte, passed through the S-box on each byte, and XORed with {rc, 00, 00, 00}. Then new w0 = old w0 ^ t, and new wj = old wj ^ new w(j-1) for j = 1 to 3. For cipher key 000102030405060708090a0b0c0d0e0f, round key 1 is d6aa74fdd2af72fadaa678f1d6ab76fe.
- R5: The round constant byte rc for rounds 1 to 10 is 01, 02, 04, 08, 10, 20, 40, 80, 1b, 36. Cipher key 000102030405060708090a0b0c0d0e0f gives round-10 key 13111d7fe3944a17f307a78b4d2b30c5.
- R6: Once the sequence has ended, with rkey_vld_o at 0 and no load, rkey_o and round_o hold their values. They therefore still show the round-10 key and index 10.
- R7: In the cycle in which round_o first shows 10, final_key_o equals the round-10 key and final_vld_o is 1. Both hold until the next load or reset.
- R8: A load during a running sequence restarts it at round 0 with the new key. On the following cycle final_vld_o is 0. The later round-10 key belongs to the new cipher key only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Capture cipher_key_i and start a new schedule |
| cipher_key_i | input | 128 | Cipher key, word 0 in bits 127:96 |
| rkey_o | output | 128 | Current round key |
| round_o | output | 4 | Index of the round key on rkey_o |
| rkey_vld_o | output | 1 | rkey_o carries a round key of the running sequence |
| final_key_o | output | 128 | Retained round-10 key, the starting key for decryption |
| final_vld_o | output | 1 | final_key_o belongs to the most recent load |

## Verification
The embedded assertions check the sequencing on every cycle: a load restarts at round 0 with the captured key, and the index rises by one per cycle without passing the last round. They also check that valid drops right after round 10, that outputs freeze when idle, and that the retained key matches the round-10 output when it appears. The arithmetic of the expansion cannot be checked that way. Rotation, byte substitution, the round-constant sequence and the word chaining only show up in the key values. These rely on the bench's known key vectors, the mid-run reload and the hold-after-completion scenarios.

// File: rtl/kx_pkg.sv
package kx_pkg;

   typedef logic [31:0] word_t;

   // multiply by x modulo x^8+x^4+x^3+x+1
   function automatic logic [7:0] gf_dbl(input logic [7:0] a);
      return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
   endfunction

   function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] acc;
      logic [7:0] t;
      acc = 8'h00;
      t   = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) acc = acc ^ t;
         t = gf_dbl(t);
      end
      return acc;
   endfunction

   // a^254 is the field inverse; zero maps to zero
   function automatic logic [7:0] gf_inv(input logic [7:0] a);
      logic [7:0] sq;
      logic [7:0] prod;
      sq   = a;
      prod = 8'h01;
      for (int i = 1; i < 8; i++) begin
         sq   = gf_mul(sq, sq);
         prod = gf_mul(prod, sq);
      end
      return prod;
   endfunction

   function automatic logic [7:0] sbox_fwd(input logic [7:0] a);
      logic [7:0] b;
      b = gf_inv(a);
      return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
               ^ {b[3:0], b[7:4]} ^ 8'h63;
   endfunction

   // round constant byte x^(r-1), r counted from 1
   function automatic logic [7:0] rcon_of(input logic [3:0] r);
      logic [7:0] v;
      v = 8'h01;
      for (int i = 2; i < 16; i++) begin
         if (i <= int'(r)) v = gf_dbl(v);
      end
      return v;
   endfunction

endpackage

// File: rtl/kx_sbox.sv
module kx_sbox (
   input  logic [7:0] din,
   output logic [7:0] dout
);
   always_comb dout = kx_pkg::sbox_fwd(din);
endmodule

// File: rtl/kx_word_mix.sv
module kx_word_mix #(
   parameter int WORD_BITS = 32,
   localparam int NBYTES   = WORD_BITS / 8
) (
   input  logic [WORD_BITS-1:0] word_i,
   input  logic [7:0]           rc_i,
   output logic [WORD_BITS-1:0] mixed_o
);
   if (WORD_BITS != 32) begin : g_bad_word
      $error("kx_word_mix: WORD_BITS must be 32");
   end

   logic [WORD_BITS-1:0] rot;
   logic [WORD_BITS-1:0] sub;

   // byte a0 (most significant) moves to the least significant position
   assign rot = {word_i[WORD_BITS-9:0], word_i[WORD_BITS-1 -: 8]};

   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      kx_sbox u_sb (
         .din  (rot[8*b +: 8]),
         .dout (sub[8*b +: 8])
      );
   end

   assign mixed_o = sub ^ {rc_i, {(WORD_BITS-8){1'b0}}};
endmodule

// File: rtl/kx_round_step.sv
module kx_round_step #(
   parameter int KEY_BITS = 128,
   localparam int NWORDS  = KEY_BITS / 32
) (
   input  logic [KEY_BITS-1:0] prev_i,
   input  logic [7:0]          rc_i,
   output logic [KEY_BITS-1:0] next_o
);
   if (KEY_BITS != 128) begin : g_bad_key
      $error("kx_round_step: KEY_BITS must be 128");
   end

   logic [31:0] temp;

   kx_word_mix #(.WORD_BITS(32)) u_mix (
      .word_i  (prev_i[31:0]),
      .rc_i    (rc_i),
      .mixed_o (temp)
   );

   // word j sits at bits KEY_BITS-1-32*j downward
   for (genvar j = 0; j < NWORDS; j++) begin : g_chain
      if (j == 0) begin : g_first
         assign next_o[KEY_BITS-1 -: 32] = prev_i[KEY_BITS-1 -: 32] ^ temp;
      end else begin : g_rest
         assign next_o[KEY_BITS-1-32*j -: 32] =
            prev_i[KEY_BITS-1-32*j -: 32] ^ next_o[KEY_BITS-1-32*(j-1) -: 32];
      end
   end
endmodule

// File: rtl/aes128_rkey_seq.sv
module aes128_rkey_seq #(
   parameter int KEY_BITS   = 128,
   parameter int NUM_ROUNDS = 10,
   localparam int RND_W     = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_i,
   input  logic [KEY_BITS-1:0] cipher_key_i,
   output logic [KEY_BITS-1:0] rkey_o,
   output logic [RND_W-1:0]    round_o,
   output logic                rkey_vld_o,
   output logic [KEY_BITS-1:0] final_key_o,
   output logic                final_vld_o
);
   if (KEY_BITS != 128) begin : g_bad_key
      $error("aes128_rkey_seq: KEY_BITS must be 128");
   end
   if (NUM_ROUNDS < 2 || NUM_ROUNDS > 15) begin : g_bad_rounds
      $error("aes128_rkey_seq: NUM_ROUNDS out of range");
   end

   localparam logic [RND_W-1:0] LAST_RND = RND_W'(NUM_ROUNDS);

   logic [KEY_BITS-1:0] key_q;
   logic [KEY_BITS-1:0] key_nxt;
   logic [KEY_BITS-1:0] fin_q;
   logic [RND_W-1:0]    rnd_q;
   logic [RND_W-1:0]    rnd_inc;
   logic                vld_q;
   logic                fin_vld_q;
   logic [7:0]          rc;

   assign rnd_inc = rnd_q + 1'b1;
   assign rc      = kx_pkg::rcon_of(rnd_inc);

   kx_round_step #(.KEY_BITS(KEY_BITS)) u_step (
      .prev_i (key_q),
      .rc_i   (rc),
      .next_o (key_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         key_q     <= '0;
         fin_q     <= '0;
         rnd_q     <= '0;
         vld_q     <= 1'b0;
         fin_vld_q <= 1'b0;
      end else if (load_i) begin
         key_q     <= cipher_key_i;
         rnd_q     <= '0;
         vld_q     <= 1'b1;
         fin_vld_q <= 1'b0;
      end else if (vld_q) begin
         if (rnd_q == LAST_RND) begin
            vld_q <= 1'b0;
         end else begin
            key_q <= key_nxt;
            rnd_q <= rnd_inc;
            if (rnd_inc == LAST_RND) begin
               fin_q     <= key_nxt;
               fin_vld_q <= 1'b1;
            end
         end
      end
   end

   assign rkey_o      = key_q;
   assign round_o     = rnd_q;
   assign rkey_vld_o  = vld_q;
   assign final_key_o = fin_q;
   assign final_vld_o = fin_vld_q;

   // R2
   load_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (rkey_vld_o && round_o == '0 && rkey_o == $past(cipher_key_i)));

   // R3
   round_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rkey_vld_o && !load_i && round_o != LAST_RND) |=> (rkey_vld_o && round_o == $past(round_o) + 1'b1));

   // R3
   round_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      round_o <= LAST_RND);

   // R3
   valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rkey_vld_o && !load_i && round_o == LAST_RND) |=> !rkey_vld_o);

   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rkey_vld_o && !load_i) |=> ($stable(rkey_o) && $stable(round_o) && !rkey_vld_o));

   // R7
   final_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rkey_vld_o && round_o == LAST_RND) |-> (final_vld_o && final_key_o == rkey_o));

   // R8
   final_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> !final_vld_o);

   // R7
   final_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (final_vld_o && !load_i) |=> (final_vld_o && $stable(final_key_o)));
endmodule

// File: tb/tb_aes128_rkey_seq.sv
module tb_aes128_rkey_seq;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         load_i = 1'b0;
   logic [127:0] cipher_key_i = '0;
   logic [127:0] rkey_o;
   logic [3:0]   round_o;
   logic         rkey_vld_o;
   logic [127:0] final_key_o;
   logic         final_vld_o;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #10 clk = ~clk;

   aes128_rkey_seq dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_i       (load_i),
      .cipher_key_i (cipher_key_i),
      .rkey_o       (rkey_o),
      .round_o      (round_o),
      .rkey_vld_o   (rkey_vld_o),
      .final_key_o  (final_key_o),
      .final_vld_o  (final_vld_o)
   );

   // {cipher key, round-1 key, round-10 key}
   localparam logic [383:0] VEC [3] = '{
      {128'h000102030405060708090a0b0c0d0e0f,
       128'hd6aa74fdd2af72fadaa678f1d6ab76fe,
       128'h13111d7fe3944a17f307a78b4d2b30c5},
      {128'h2b7e151628aed2a6abf7158809cf4f3c,
       128'ha0fafe1788542cb123a339392a6c7605,
       128'hd014f9a8c9ee2589e13f0cc8b6630ca6},
      {128'h00000000000000000000000000000000,
       128'h62636363626363636263636362636363,
       128'hb4ef5bcb3e92e21123e951cf6f8f188e}
   };

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic do_load(input logic [127:0] k);
      @(negedge clk);
      load_i       = 1'b1;
      cipher_key_i = k;
      @(negedge clk);
      load_i       = 1'b0;
      cipher_key_i = ~k;
   endtask

   task automatic run_vec(input logic [127:0] k, input logic [127:0] r1, input logic [127:0] r10);
      do_load(k);
      chk("R2 key0", rkey_o, k);
      chk("R2 round/valid", {124'd0, round_o}, 128'd0);
      chk("R2 valid", {127'd0, rkey_vld_o}, 128'd1);
      for (int r = 1; r <= 10; r++) begin
         @(negedge clk);
         chk("R3 index", {123'd0, rkey_vld_o, round_o}, {123'd0, 1'b1, 4'(r)});
         if (r == 1)  chk("R4 round1 key", rkey_o, r1);
         if (r == 10) begin
            chk("R5 round10 key", rkey_o, r10);
            chk("R7 final key", final_key_o, r10);
            chk("R7 final valid", {127'd0, final_vld_o}, 128'd1);
         end
      end
      @(negedge clk);
      chk("R3 valid drop", {127'd0, rkey_vld_o}, 128'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 valid", {126'd0, rkey_vld_o, final_vld_o}, 128'd0);
      chk("R1 round", {124'd0, round_o}, 128'd0);
      chk("R1 rkey", rkey_o, 128'd0);
      chk("R1 final", final_key_o, 128'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", {123'd0, rkey_vld_o, round_o}, 128'd0);

      for (int v = 0; v < 3; v++) begin
         run_vec(VEC[v][383:256], VEC[v][255:128], VEC[v][127:0]);
      end

      // R6 hold after completion (last vector: zero key)
      repeat (4) @(negedge clk);
      chk("R6 hold key", rkey_o, VEC[2][127:0]);
      chk("R6 hold round", {123'd0, rkey_vld_o, round_o}, {123'd0, 1'b0, 4'd10});
      chk("R7 final hold", final_key_o, VEC[2][127:0]);

      // R8 restart mid-run: start vector 0, reload vector 1 at round 5
      do_load(VEC[0][383:256]);
      repeat (5) @(negedge clk);
      chk("R8 pre-reload round", {124'd0, round_o}, 128'd5);
      do_load(VEC[1][383:256]);
      chk("R8 restart key", rkey_o, VEC[1][383:256]);
      chk("R8 restart round", {123'd0, rkey_vld_o, round_o}, {123'd0, 1'b1, 4'd0});
      chk("R8 final cleared", {127'd0, final_vld_o}, 128'd0);
      repeat (10) @(negedge clk);
      chk("R8 new round10", rkey_o, VEC[1][127:0]);
      chk("R8 new final", final_key_o, VEC[1][127:0]);

      // R8 load while final key valid clears it
      @(negedge clk);
      do_load(VEC[0][383:256]);
      chk("R8 final cleared on reload", {127'd0, final_vld_o}, 128'd0);
      @(negedge clk);
      chk("R4 round1 after reload", rkey_o, VEC[0][255:128]);

      // R1 reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 mid-run reset", {122'd0, rkey_vld_o, final_vld_o, round_o}, 128'd0);
      chk("R1 mid-run reset key", rkey_o | final_key_o, 128'd0);
      rst_n = 1'b1;

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog act=timeout exp=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule